// File: doc/BRIEF.md
# Accelerated Test-Mode Entry Detector

This block watches the two active-low manual reset lines of a dual-input reset generator and recognizes a deliberate request to run the delay timer in accelerated form. The request is made in a fixed way. The first line is pulled low while the second is still high. After a minimum setup time, a burst of fast pulses is applied to the second line. When the burst holds enough pulses inside a qualification window, the block raises a test-active flag. The flag replaces the long normal timeout with a short fixed delay. At the end of that delay the block sends one fire request to the reset pulse generator and goes back to idle.

Both lines are sampled by a fast system clock through a two-flop synchronizer, followed by one edge-detect register. The system clock must run at least four times faster than the test burst, so that the shortest burst pulse is still seen. A failed attempt is simply dropped and leaves no trace. An attempt fails when the setup is too short, when too few pulses arrive, when the eighth pulse comes late, or when the first line is released early. During the delay, raising both lines together cancels test mode at once, and no fire request is sent.

Top module: `tmode_entry_detect`

## Requirements
- R1: While reset is held, and in the cycle after it, `test_active` and `fire_req` are both 0. Both lines idle high (1 = released, 0 = pressed).
- R2: An attempt starts only when `mr_a_n` falls while `mr_b_n` is high. If `mr_a_n` falls while `mr_b_n` is already low, nothing happens. If the first fall of `mr_b_n` comes SETUP_CYC cycles or less after the fall of `mr_a_n` (both measured at the pins), the attempt is dropped.
- R3: Test mode is entered when PULSES (default 8) rising edges of `mr_b_n` arrive no more than WINDOW_CYC cycles after its first fall. `test_active` rises exactly 3 clock cycles after the eighth rising edge is driven on the pin.
- R4: An attempt is dropped, with no `test_active` and no `fire_req`, in two cases: fewer than PULSES rising edges arrive, or the last one comes more than WINDOW_CYC cycles after the first fall.
- R5: A rise of `mr_a_n` before test mode is entered drops the attempt. Later pulses on `mr_b_n` then have no effect.
- R6: `test_active` stays high for exactly DELAY_CYC cycles. In the cycle where it falls, `fire_req` is high for exactly one cycle.
- R7: If both lines are high while `test_active` is set, `test_active` falls 3 cycles after the pins are driven, and `fire_req` is never raised for that attempt.
- R8: After a fire request the block needs a new fall of `mr_a_n` to start again. Further pulses on `mr_b_n` while `mr_a_n` stays low do not enter test mode again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| mr_a_n | input | 1 | First manual line, active low, asynchronous |
| mr_b_n | input | 1 | Second manual line, active low, carries the test burst |
| test_active | output | 1 | High during the shortened test delay |
| fire_req | output | 1 | One-cycle request for a standard reset pulse |

## Verification
Faults in the state or in a counter show up at the ports with fixed, short latency.

- A pulse counter that is off by one makes `test_active` rise one pulse early, three cycles after the seventh edge, or one pulse late.
- A delay timer fault moves the `fire_req` cycle away from exactly DELAY_CYC cycles after `test_active` rises.
- A window or setup comparison error turns an attempt near the limits into the wrong outcome. This is visible within WINDOW_CYC cycles.
- A missing both-high exit leaves `test_active` high three cycles after release, when it should already be low.

// File: rtl/tmode_pkg.sv
package tmode_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_ARMED = 3'd2,
        ST_QUAL  = 3'd3,
        ST_DELAY = 3'd4
    } tm_state_e;

    // Level and edge information for one synchronized line
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } line_s;

    localparam int unsigned LANE_A = 0;
    localparam int unsigned LANE_B = 1;

    function automatic int unsigned bits_for(input longint unsigned maxv);
        int unsigned w;
        w = 1;
        while ((64'd1 << w) <= maxv) w++;
        return w;
    endfunction

    function automatic longint unsigned max3(input longint unsigned a,
                                             input longint unsigned b,
                                             input longint unsigned c);
        longint unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/tmode_sync.sv
module tmode_sync #(
    parameter int unsigned LANES    = 2,
    parameter int unsigned STAGES   = 2,
    parameter logic        IDLE_LVL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] d,
    output logic [LANES-1:0] q
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{IDLE_LVL}};
            else     chain <= {chain[STAGES-2:0], d[g]};
        end
        assign q[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/tmode_edge.sv
module tmode_edge
    import tmode_pkg::*;
#(
    parameter int unsigned LANES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANES-1:0]       lvl,
    output line_s [LANES-1:0]      ln
);
    logic [LANES-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= lvl;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_edge
        assign ln[g].lvl  = lvl[g];
        assign ln[g].rise = lvl[g] & ~prev_q[g];
        assign ln[g].fall = ~lvl[g] & prev_q[g];
    end
endmodule

// File: rtl/tmode_timer.sv
module tmode_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)      cnt <= '0;
        else if (cnt != '1)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tmode_pulse_count.sv
module tmode_pulse_count
    import tmode_pkg::*;
#(
    parameter int unsigned PULSES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int unsigned PW = bits_for(longint'(PULSES));
    localparam logic [PW-1:0] LAST_VAL = PW'(PULSES - 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)                 cnt_q <= '0;
        else if (inc && cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == LAST_VAL);
endmodule

// File: rtl/tmode_entry_detect.sv
module tmode_entry_detect
    import tmode_pkg::*;
#(
    parameter int unsigned SETUP_CYC  = 100_000,
    parameter int unsigned WINDOW_CYC = 3_500_000,
    parameter int unsigned DELAY_CYC  = 25_000_000,
    parameter int unsigned PULSES     = 8,
    parameter int unsigned SYNC_STG   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mr_a_n,
    input  logic mr_b_n,
    output logic test_active,
    output logic fire_req
);
    localparam longint unsigned MAX_CYC =
        max3(longint'(SETUP_CYC), longint'(WINDOW_CYC), longint'(DELAY_CYC));
    localparam int unsigned TW = bits_for(MAX_CYC);
    localparam logic [TW-1:0] SETUP_LAST  = TW'(SETUP_CYC - 1);
    localparam logic [TW-1:0] WINDOW_LAST = TW'(WINDOW_CYC - 1);
    localparam logic [TW-1:0] DELAY_LAST  = TW'(DELAY_CYC - 1);

    logic [1:0]        raw;
    logic [1:0]        synced;
    line_s [1:0]       lines;
    line_s             la, lb;
    logic              a_s, b_s;
    tm_state_e         st, st_nx;
    logic [TW-1:0]     tmr;
    logic              tmr_clr;
    logic              pc_clr, pc_last;
    logic              fire_d, fire_q;

    assign raw[LANE_A] = mr_a_n;
    assign raw[LANE_B] = mr_b_n;

    tmode_sync #(.LANES(2), .STAGES(SYNC_STG), .IDLE_LVL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(synced)
    );

    tmode_edge #(.LANES(2)) u_edge (
        .clk(clk), .rst(rst), .lvl(synced), .ln(lines)
    );

    assign la  = lines[LANE_A];
    assign lb  = lines[LANE_B];
    assign a_s = la.lvl;
    assign b_s = lb.lvl;

    tmode_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst(rst), .clr(tmr_clr), .cnt(tmr)
    );

    tmode_pulse_count #(.PULSES(PULSES)) u_pc (
        .clk(clk), .rst(rst), .clr(pc_clr),
        .inc(lb.rise), .last(pc_last)
    );

    // Next-state selection; the shared timer restarts on every state change
    always_comb begin
        st_nx  = st;
        fire_d = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (la.fall && lb.lvl) st_nx = ST_SETUP;
            end
            ST_SETUP: begin
                if (la.rise || lb.fall)    st_nx = ST_IDLE;
                else if (tmr == SETUP_LAST) st_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (la.rise)      st_nx = ST_IDLE;
                else if (lb.fall) st_nx = ST_QUAL;
            end
            ST_QUAL: begin
                if (la.rise)                   st_nx = ST_IDLE;
                else if (lb.rise && pc_last)   st_nx = ST_DELAY;
                else if (tmr == WINDOW_LAST)   st_nx = ST_IDLE;
            end
            ST_DELAY: begin
                if (la.lvl && lb.lvl) begin
                    st_nx = ST_IDLE;
                end else if (tmr == DELAY_LAST) begin
                    st_nx  = ST_IDLE;
                    fire_d = 1'b1;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    assign tmr_clr = (st_nx != st);
    assign pc_clr  = (st != ST_QUAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            fire_q <= 1'b0;
        end else begin
            st     <= st_nx;
            fire_q <= fire_d;
        end
    end

    assign test_active = (st == ST_DELAY);
    assign fire_req    = fire_q;
endmodule

// File: rtl/tmode_entry_checker.sv
module tmode_entry_checker
    import tmode_pkg::*;
#(
    parameter int unsigned DELAY_CYC = 16
) (
    input logic      clk,
    input logic      rst,
    input logic      test_active,
    input logic      fire_req,
    input logic      a_lvl,
    input logic      b_lvl,
    input tm_state_e st
);
    logic [31:0] act_cnt;
    logic        rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst)              act_cnt <= '0;
        else if (test_active) act_cnt <= act_cnt + 32'd1;
        else                  act_cnt <= '0;
    end

    always @(negedge clk) begin
        if (rst_q === 1'b1)
            a_r1_reset_quiet: assert (!test_active && !fire_req);
    end

    a_r6_single_fire: assert property (@(posedge clk) disable iff (rst)
        fire_req |=> !fire_req);

    a_r6_fire_after_delay: assert property (@(posedge clk) disable iff (rst)
        fire_req |-> (act_cnt == DELAY_CYC && !test_active));

    a_r6_active_bounded: assert property (@(posedge clk) disable iff (rst)
        test_active |-> (act_cnt < DELAY_CYC));

    a_r7_both_high_exit: assert property (@(posedge clk) disable iff (rst)
        (test_active && a_lvl && b_lvl) |=> (!test_active && !fire_req));

    a_r3_entry_from_qual: assert property (@(posedge clk) disable iff (rst)
        $rose(test_active) |-> ($past(st) == ST_QUAL));
endmodule

bind tmode_entry_detect tmode_entry_checker #(.DELAY_CYC(DELAY_CYC)) u_chk (
    .clk(clk), .rst(rst), .test_active(test_active), .fire_req(fire_req),
    .a_lvl(a_s), .b_lvl(b_s), .st(st)
);

// File: tb/tmode_entry_detect_bench.sv
module tmode_entry_detect_bench;
    localparam int SETUP  = 20;
    localparam int WINDOW = 200;
    localparam int DELAY  = 300;
    localparam int NPULSE = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mr_a_n = 1'b1;
    logic mr_b_n = 1'b1;
    logic test_active, fire_req;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int fire_cnt = 0, fire_cyc = -1;
    int act_cnt = 0, act_cyc = -1;
    logic act_prev = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tmode_entry_detect #(
        .SETUP_CYC(SETUP), .WINDOW_CYC(WINDOW), .DELAY_CYC(DELAY)
    ) u_tmode_entry_detect (
        .clk(clk), .rst(rst), .mr_a_n(mr_a_n), .mr_b_n(mr_b_n),
        .test_active(test_active), .fire_req(fire_req)
    );

    always @(negedge clk) begin
        if (fire_req) begin
            fire_cnt = fire_cnt + 1;
            fire_cyc = cyc;
        end
        if (test_active && !act_prev) begin
            act_cnt = act_cnt + 1;
            act_cyc = cyc;
        end
        act_prev = test_active;
    end

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    function automatic bit setup_ok(input int a_fall, input int b_fall);
        return (b_fall - a_fall) > SETUP;
    endfunction

    function automatic bit window_ok(input int b_fall, input int last_rise);
        return (last_rise - b_fall) <= WINDOW;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press_a(output int t);
        mr_a_n = 1'b0;
        t = cyc;
    endtask

    // Burst on the second line; reports first fall and the PULSES-th rise
    task automatic burst(input int n, input int lo, input int hi,
                         output int first_fall, output int last_rise);
        first_fall = -1;
        last_rise  = -1;
        for (int i = 0; i < n; i++) begin
            mr_b_n = 1'b0;
            if (i == 0) first_fall = cyc;
            idle(lo);
            mr_b_n = 1'b1;
            if (i == NPULSE - 1) last_rise = cyc;
            idle(hi);
        end
    endtask

    task automatic release_all();
        mr_a_n = 1'b1;
        mr_b_n = 1'b1;
        idle(10);
    endtask

    task automatic attempt(input string req, input int gap, input int n,
                           input int lo, input int hi);
        int ta, tf, tr, f0, a0;
        bit exp_entry;
        f0 = fire_cnt;
        a0 = act_cnt;
        press_a(ta);
        idle(gap);
        burst(n, lo, hi, tf, tr);
        exp_entry = setup_ok(ta, tf) && (n >= NPULSE) && window_ok(tf, tr);
        if (exp_entry) begin
            idle(DELAY + 10);
            check({req, " entry count"}, act_cnt - a0, 1);
            check({req, " R3 active latency"}, act_cyc, tr + 3);
            check({req, " R6 fire count"}, fire_cnt - f0, 1);
            check({req, " R6 fire timing"}, fire_cyc, tr + 3 + DELAY);
        end else begin
            idle(WINDOW + 20);
            check({req, " no entry"}, act_cnt - a0, 0);
            check({req, " no fire"}, fire_cnt - f0, 0);
        end
        release_all();
    endtask

    initial begin
        int ta, tf, tr, f0, a0, rv;
        rv = $urandom(32'd1234);
        idle(3);
        check("R1 active in reset", int'(test_active), 0);
        check("R1 fire in reset", int'(fire_req), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 active after reset", int'(test_active), 0);
        check("R1 fire after reset", int'(fire_req), 0);
        idle(5);

        // R3 R6: clean entry
        attempt("R3 valid", 40, 8, 4, 4);
        // R4: seven pulses only
        attempt("R4 seven pulses", 40, 7, 4, 4);
        // R4: eighth pulse beyond window
        attempt("R4 late eighth", 40, 8, 14, 14);
        // R2: second line falls during setup
        attempt("R2 short setup", 5, 8, 4, 4);

        // R2: first line falls while second already low
        f0 = fire_cnt; a0 = act_cnt;
        mr_b_n = 1'b0; idle(5);
        press_a(ta); idle(40);
        mr_b_n = 1'b1; idle(4);
        burst(8, 4, 4, tf, tr);
        idle(DELAY + 10);
        check("R2 second low first", act_cnt - a0, 0);
        release_all();

        // R5: first line released mid qualification
        f0 = fire_cnt; a0 = act_cnt;
        press_a(ta); idle(40);
        burst(4, 4, 4, tf, tr);
        mr_a_n = 1'b1; idle(4);
        burst(8, 4, 4, tf, tr);
        idle(DELAY + 10);
        check("R5 no entry", act_cnt - a0, 0);
        check("R5 no fire", fire_cnt - f0, 0);
        release_all();

        // R7: both high during delay
        f0 = fire_cnt; a0 = act_cnt;
        press_a(ta); idle(40);
        burst(8, 4, 4, tf, tr);
        idle(50);
        check("R7 active before abort", int'(test_active), 1);
        mr_a_n = 1'b1;
        idle(2);
        check("R7 still active 2 cycles", int'(test_active), 1);
        idle(1);
        check("R7 dropped 3 cycles", int'(test_active), 0);
        idle(DELAY + 10);
        check("R7 no fire", fire_cnt - f0, 0);
        release_all();

        // R8: hold first line after fire, more bursts
        f0 = fire_cnt; a0 = act_cnt;
        press_a(ta); idle(40);
        burst(8, 4, 4, tf, tr);
        idle(DELAY + 10);
        check("R8 first fire", fire_cnt - f0, 1);
        burst(8, 4, 4, tf, tr);
        idle(DELAY + 10);
        check("R8 no re-entry", act_cnt - a0, 1);
        check("R8 no second fire", fire_cnt - f0, 1);
        release_all();

        // Random attempts near the setup and window limits
        for (int k = 0; k < 20; k++) begin
            int gap, n, lo, hi;
            gap = SETUP - 5 + int'($urandom % 30);
            n   = 6 + int'($urandom % 4);
            lo  = 4 + int'($urandom % 10);
            hi  = 4 + int'($urandom % 10);
            attempt("R2 R3 R4 random", gap, n, lo, hi);
        end

        finish_run();
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
            finish_run();
        end
    end
endmodule